// File: doc/BRIEF.md
# Shared-Memory Board Address Decoder

This block sits on the host side of a peripheral board that exposes a 4 KB shared memory window and two single-bit registers. It watches a 21-bit host address, an external enable and two active-low strobes (read and write). From these it produces at most one select at a time. The select is a memory read, a memory write, or a read or write of one of the two registers. It also passes the memory word address straight through to the array.

The block holds both registers. The control register keeps a single bit written by the host. The flag register keeps a single bit that the host or the far-side processor may write. It also keeps a status bit that records a far-side write until the host reads the flag register. Register reads return their bits on the data output, and every other bit reads as zero. The memory array and the far-side processor are outside the block.

The board answers at host base 0xB00000. Within the 21-bit address this is bit 20 set and bits 16 to 19 clear. The offset is address bits 15:0.

Top module: `sm_decoder`

## Requirements
- R1: A select is possible only when address bits 19:16 are all zero and both address bit 20 and `ext_en` are high; otherwise all six selects stay low.
- R2: Offsets 0x0000 to 0x0FFF assert `mem_rd_sel` on a read and `mem_wr_sel` on a write, and `mem_word_addr` always equals address bits 11:1.
- R3: Offset 0x1000 asserts `ctl_rd_sel`/`ctl_wr_sel`; a write stores `wdata[0]` at the next clock edge and a later read returns it on `rdata[0]`.
- R4: Offset 0x1002 asserts `flg_rd_sel`/`flg_wr_sel`; a host write stores `wdata[0]`, and a read returns that bit on `rdata[0]`.
- R5: A pulse on `far_wr` sets the status bit, which a flag read returns on `rdata[7]`; a host flag read clears it at the end of that cycle, and a set in the same cycle as the clearing read wins.
- R6: A pulse on `far_wr` loads `far_bit` into the flag bit, taking priority over a host flag write in the same cycle.
- R7: A read is `rd_n`=0 with `wr_n`=1, and a write is `wr_n`=0 with `rd_n`=1; both low or both high asserts no select, and at most one select is ever high.
- R8: Offsets outside the three slots (for example 0x1001, 0x1004, 0x2000) assert no select.
- R9: `rdata` bits other than 0 and 7 are always zero, and `rdata` is all zero unless a register read select is asserted.
- R10: A synchronous active-high `rst` clears the control bit, the flag bit and the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 21 | Host byte address |
| ext_en | input | 1 | External enable, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 16 | Host write data |
| far_wr | input | 1 | Far-side flag write pulse |
| far_bit | input | 1 | Far-side flag value |
| mem_rd_sel | output | 1 | Memory read select |
| mem_wr_sel | output | 1 | Memory write select |
| ctl_rd_sel | output | 1 | Control register read select |
| ctl_wr_sel | output | 1 | Control register write select |
| flg_rd_sel | output | 1 | Flag register read select |
| flg_wr_sel | output | 1 | Flag register write select |
| mem_word_addr | output | 11 | Word address to the memory array |
| rdata | output | 16 | Register read data |

## Verification
The decode is tried with the following address and strobe patterns:
- Both ends and the middle of the memory window, which show whether the window edge is drawn at the right bit.
- The two register slots, each under read and under write.
- Offsets next to the slots, such as odd bytes and the following word, which separate a full compare from a partial one.
- Addresses where each match bit fails alone, which prove that every term of the board match is needed.
- All four strobe combinations, to prove that both-low and both-high are rejected.

Directed sequences cover the register state. They write all-ones data to confirm that only bit 0 is stored. They issue far-side writes that coincide with a host write or with a host read, which separates the two priority rules. They also check that reset clears state set just before it.

// File: rtl/sm_decoder_pkg.sv
package sm_decoder_pkg;
   typedef struct packed {
      logic flg_wr;
      logic flg_rd;
      logic ctl_wr;
      logic ctl_rd;
      logic mem_wr;
      logic mem_rd;
   } sel_t;

   localparam sel_t SEL_NONE = '0;
endpackage

// File: rtl/sm_board_match.sv
module sm_board_match #(
   parameter int ADDR_W = 21,
   parameter int ZERO_LO = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              ext_en,
   output logic              hit
);
   localparam int ZERO_HI = ADDR_W - 2;

   initial begin
      if (ZERO_LO > ZERO_HI) $error("sm_board_match: empty zero field");
   end

   always_comb begin
      hit = addr[ADDR_W-1] && ext_en && (addr[ZERO_HI:ZERO_LO] == '0);
   end
endmodule

// File: rtl/sm_slot_decode.sv
module sm_slot_decode
   import sm_decoder_pkg::*;
#(
   parameter int              OFS_W    = 16,
   parameter int              WIN_BITS = 12,
   parameter logic [OFS_W-1:0] CTL_OFS = 16'h1000,
   parameter logic [OFS_W-1:0] FLG_OFS = 16'h1002
) (
   input  logic             hit,
   input  logic [OFS_W-1:0] ofs,
   input  logic             rd_n,
   input  logic             wr_n,
   output sel_t             sel
);
   logic is_rd, is_wr, in_mem, in_ctl, in_flg;

   always_comb begin
      is_rd  = hit && !rd_n && wr_n;
      is_wr  = hit && !wr_n && rd_n;
      in_mem = (ofs[OFS_W-1:WIN_BITS] == '0);
      in_ctl = (ofs == CTL_OFS);
      in_flg = (ofs == FLG_OFS);
      sel        = SEL_NONE;
      sel.mem_rd = is_rd && in_mem;
      sel.mem_wr = is_wr && in_mem;
      sel.ctl_rd = is_rd && in_ctl;
      sel.ctl_wr = is_wr && in_ctl;
      sel.flg_rd = is_rd && in_flg;
      sel.flg_wr = is_wr && in_flg;
   end
endmodule

// File: rtl/sm_bit_regs.sv
module sm_bit_regs #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic ctl_we,
   input  logic flg_we,
   input  logic flg_re,
   input  logic host_bit,
   input  logic far_wr,
   input  logic far_bit,
   output logic ctl_q,
   output logic flg_q,
   output logic stat_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_q <= 1'b0;
         flg_q <= 1'b0;
      end else begin
         if (ctl_we) ctl_q <= host_bit;
         if (far_wr)      flg_q <= far_bit;
         else if (flg_we) flg_q <= host_bit;
      end
   end

   generate
      if (SET_WINS) begin : g_set_wins
         always_ff @(posedge clk) begin
            if (rst)         stat_q <= 1'b0;
            else if (far_wr) stat_q <= 1'b1;
            else if (flg_re) stat_q <= 1'b0;
         end
      end else begin : g_clear_wins
         always_ff @(posedge clk) begin
            if (rst)         stat_q <= 1'b0;
            else if (flg_re) stat_q <= 1'b0;
            else if (far_wr) stat_q <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/sm_decoder.sv
module sm_decoder
   import sm_decoder_pkg::*;
#(
   parameter int ADDR_W     = 21,
   parameter int DATA_W     = 16,
   parameter int OFS_W      = 16,
   parameter int WIN_BITS   = 12,
   parameter int ZERO_LO    = 16,
   parameter int STATUS_BIT = 7,
   parameter bit SET_WINS   = 1'b1,
   localparam int WA_W      = WIN_BITS - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ext_en,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic              far_wr,
   input  logic              far_bit,
   output logic              mem_rd_sel,
   output logic              mem_wr_sel,
   output logic              ctl_rd_sel,
   output logic              ctl_wr_sel,
   output logic              flg_rd_sel,
   output logic              flg_wr_sel,
   output logic [WA_W-1:0]   mem_word_addr,
   output logic [DATA_W-1:0] rdata
);
   initial begin
      if (STATUS_BIT < 1 || STATUS_BIT >= DATA_W) $error("sm_decoder: STATUS_BIT out of range");
      if (WIN_BITS < 2 || WIN_BITS >= OFS_W)      $error("sm_decoder: WIN_BITS out of range");
      if (OFS_W > ZERO_LO)                        $error("sm_decoder: offset overlaps match field");
   end

   logic hit;
   sel_t sel;
   logic ctl_q, flg_q, stat_q;

   sm_board_match #(.ADDR_W(ADDR_W), .ZERO_LO(ZERO_LO)) u_match (
      .addr  (addr),
      .ext_en(ext_en),
      .hit   (hit)
   );

   sm_slot_decode #(.OFS_W(OFS_W), .WIN_BITS(WIN_BITS)) u_slots (
      .hit (hit),
      .ofs (addr[OFS_W-1:0]),
      .rd_n(rd_n),
      .wr_n(wr_n),
      .sel (sel)
   );

   sm_bit_regs #(.SET_WINS(SET_WINS)) u_regs (
      .clk     (clk),
      .rst     (rst),
      .ctl_we  (sel.ctl_wr),
      .flg_we  (sel.flg_wr),
      .flg_re  (sel.flg_rd),
      .host_bit(wdata[0]),
      .far_wr  (far_wr),
      .far_bit (far_bit),
      .ctl_q   (ctl_q),
      .flg_q   (flg_q),
      .stat_q  (stat_q)
   );

   always_comb begin
      mem_rd_sel    = sel.mem_rd;
      mem_wr_sel    = sel.mem_wr;
      ctl_rd_sel    = sel.ctl_rd;
      ctl_wr_sel    = sel.ctl_wr;
      flg_rd_sel    = sel.flg_rd;
      flg_wr_sel    = sel.flg_wr;
      mem_word_addr = addr[WIN_BITS-1:1];
      rdata         = '0;
      if (sel.ctl_rd) rdata[0] = ctl_q;
      if (sel.flg_rd) begin
         rdata[0]          = flg_q;
         rdata[STATUS_BIT] = stat_q;
      end
   end
endmodule

// File: rtl/sm_decoder_chk.sv
module sm_decoder_chk #(
   parameter int ADDR_W     = 21,
   parameter int DATA_W     = 16,
   parameter int ZERO_LO    = 16,
   parameter int STATUS_BIT = 7
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] addr,
   input logic              ext_en,
   input logic              rd_n,
   input logic              wr_n,
   input logic [DATA_W-1:0] wdata,
   input logic              far_wr,
   input logic              far_bit,
   input logic              mem_rd_sel,
   input logic              mem_wr_sel,
   input logic              ctl_rd_sel,
   input logic              ctl_wr_sel,
   input logic              flg_rd_sel,
   input logic              flg_wr_sel,
   input logic [DATA_W-1:0] rdata
);
   logic [5:0] sels;
   logic [DATA_W-1:0] free_mask;
   assign sels = {flg_wr_sel, flg_rd_sel, ctl_wr_sel, ctl_rd_sel, mem_wr_sel, mem_rd_sel};
   always_comb begin
      free_mask = '1;
      free_mask[0] = 1'b0;
      free_mask[STATUS_BIT] = 1'b0;
   end

   assert_one_select_R7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sels));

   assert_strobe_conflict_R7: assert property (@(posedge clk) disable iff (rst)
      (rd_n == wr_n) |-> (sels == '0));

   assert_board_miss_R1: assert property (@(posedge clk) disable iff (rst)
      !(addr[ADDR_W-1] && ext_en && addr[ADDR_W-2:ZERO_LO] == '0) |-> (sels == '0));

   assert_free_bits_zero_R9: assert property (@(posedge clk) disable iff (rst)
      (rdata & free_mask) == '0);

   assert_ctl_roundtrip_R3: assert property (@(posedge clk) disable iff (rst)
      ctl_wr_sel |=> (!ctl_rd_sel || rdata[0] == $past(wdata[0])));

   assert_status_set_R5: assert property (@(posedge clk) disable iff (rst)
      far_wr |=> (!flg_rd_sel || rdata[STATUS_BIT]));

   assert_far_value_R6: assert property (@(posedge clk) disable iff (rst)
      far_wr |=> (!flg_rd_sel || rdata[0] == $past(far_bit)));
endmodule

bind sm_decoder sm_decoder_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ZERO_LO(ZERO_LO), .STATUS_BIT(STATUS_BIT)
) u_chk (
   .clk(clk), .rst(rst), .addr(addr), .ext_en(ext_en), .rd_n(rd_n), .wr_n(wr_n),
   .wdata(wdata), .far_wr(far_wr), .far_bit(far_bit),
   .mem_rd_sel(mem_rd_sel), .mem_wr_sel(mem_wr_sel),
   .ctl_rd_sel(ctl_rd_sel), .ctl_wr_sel(ctl_wr_sel),
   .flg_rd_sel(flg_rd_sel), .flg_wr_sel(flg_wr_sel), .rdata(rdata)
);

// File: tb/test_sm_decoder.sv
module test_sm_decoder;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [20:0] addr = '0;
   logic        ext_en = 1'b0;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [15:0] wdata = '0;
   logic        far_wr = 1'b0;
   logic        far_bit = 1'b0;
   logic        mem_rd_sel, mem_wr_sel, ctl_rd_sel, ctl_wr_sel, flg_rd_sel, flg_wr_sel;
   logic [10:0] mem_word_addr;
   logic [15:0] rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   sm_decoder i_sm_decoder (
      .clk(clk), .rst(rst), .addr(addr), .ext_en(ext_en), .rd_n(rd_n), .wr_n(wr_n),
      .wdata(wdata), .far_wr(far_wr), .far_bit(far_bit),
      .mem_rd_sel(mem_rd_sel), .mem_wr_sel(mem_wr_sel),
      .ctl_rd_sel(ctl_rd_sel), .ctl_wr_sel(ctl_wr_sel),
      .flg_rd_sel(flg_rd_sel), .flg_wr_sel(flg_wr_sel),
      .mem_word_addr(mem_word_addr), .rdata(rdata)
   );

   // select code bits: 0 mem_rd, 1 mem_wr, 2 ctl_rd, 3 ctl_wr, 4 flg_rd, 5 flg_wr
   // vector: addr(21) ext_en rd_n wr_n expected_sel(6)
   typedef struct packed {
      logic [20:0] a;
      logic        en;
      logic        r;
      logic        w;
      logic [5:0]  s;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{21'h100000, 1'b1, 1'b0, 1'b1, 6'h01},  // R2 window low edge read
      '{21'h100FFF, 1'b1, 1'b1, 1'b0, 6'h02},  // R2 window high edge write
      '{21'h100246, 1'b1, 1'b0, 1'b1, 6'h01},  // R2 mid window
      '{21'h101000, 1'b1, 1'b0, 1'b1, 6'h04},  // R3 ctl read
      '{21'h101000, 1'b1, 1'b1, 1'b0, 6'h08},  // R3 ctl write
      '{21'h101002, 1'b1, 1'b0, 1'b1, 6'h10},  // R4 flag read
      '{21'h101002, 1'b1, 1'b1, 1'b0, 6'h20},  // R4 flag write
      '{21'h101001, 1'b1, 1'b0, 1'b1, 6'h00},  // R8 odd byte
      '{21'h101004, 1'b1, 1'b0, 1'b1, 6'h00},  // R8 next word
      '{21'h102000, 1'b1, 1'b0, 1'b1, 6'h00},  // R8 past slots
      '{21'h110000, 1'b1, 1'b0, 1'b1, 6'h00},  // R1 bit16 set
      '{21'h180000, 1'b1, 1'b0, 1'b1, 6'h00},  // R1 bit19 set
      '{21'h000000, 1'b1, 1'b0, 1'b1, 6'h00},  // R1 bit20 clear
      '{21'h100010, 1'b0, 1'b0, 1'b1, 6'h00},  // R1 enable low
      '{21'h100010, 1'b1, 1'b0, 1'b0, 6'h00},  // R7 both strobes low
      '{21'h100010, 1'b1, 1'b1, 1'b1, 6'h00}   // R7 no strobe
   };

   function automatic logic [5:0] sel_now();
      return {flg_wr_sel, flg_rd_sel, ctl_wr_sel, ctl_rd_sel, mem_wr_sel, mem_rd_sel};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive one bus cycle just after an edge; sample 4 ns later
   task automatic cyc(input logic [20:0] a, input logic r, input logic w,
                      input logic [15:0] d, input logic fw, input logic fb);
      @(posedge clk);
      #1;
      addr = a; ext_en = 1'b1; rd_n = r; wr_n = w; wdata = d; far_wr = fw; far_bit = fb;
      #4;
   endtask

   task automatic idle();
      cyc(21'h0, 1'b1, 1'b1, 16'h0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;

      // R10 reset state
      cyc(21'h101000, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0);
      check("R10 ctl after reset", rdata, 16'h0000);
      cyc(21'h101002, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0);
      check("R10 flag after reset", rdata, 16'h0000);

      // table walk
      for (int i = 0; i < NV; i++) begin
         @(posedge clk);
         #1;
         addr = VECS[i].a; ext_en = VECS[i].en; rd_n = VECS[i].r; wr_n = VECS[i].w;
         wdata = '0; far_wr = 1'b0;
         #4;
         check($sformatf("R1/R2/R7/R8 sel vec %0d", i), {26'b0, sel_now()}, {26'b0, VECS[i].s});
         check($sformatf("R2 word addr vec %0d", i), {21'b0, mem_word_addr}, {21'b0, VECS[i].a[11:1]});
      end

      // R9 memory read leaves rdata zero
      cyc(21'h100100, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0);
      check("R9 rdata on memory read", rdata, 16'h0000);

      // R3 store only bit 0
      cyc(21'h101000, 1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0);
      cyc(21'h101000, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0);
      check("R3/R9 ctl readback", rdata, 16'h0001);
      cyc(21'h101000, 1'b1, 1'b0, 16'hFFFE, 1'b0, 1'b0);
      cyc(21'h101000, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0);
      check("R3 ctl cleared", rdata, 16'h0000);

      // R4 host flag write
      cyc(21'h101002, 1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0);
      cyc(21'h101002, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0);
      check("R4 flag readback", rdata, 16'h0001);

      // R5/R6 far write sets status and value, read clears status
      cyc(21'h0, 1'b1, 1'b1, 16'h0, 1'b1, 1'b0);
      cyc(21'h101002, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0);
      check("R5/R6 status set by far write", rdata, 16'h0080);
      cyc(21'h101002, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0);
      check("R5 status cleared by read", rdata, 16'h0000);

      // R6 far write beats host write in same cycle
      cyc(21'h101002, 1'b1, 1'b0, 16'h0001, 1'b1, 1'b0);
      cyc(21'h101002, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0);
      check("R6 far value priority", rdata, 16'h0080);

      // R5 set wins over clearing read in same cycle
      cyc(21'h101002, 1'b0, 1'b1, 16'h0, 1'b1, 1'b1);
      check("R5 read during set shows old", rdata, 16'h0000);
      cyc(21'h101002, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0);
      check("R5 set wins over clear", rdata, 16'h0081);

      // R10 reset clears set state
      cyc(21'h101000, 1'b1, 1'b0, 16'h0001, 1'b1, 1'b1);
      @(posedge clk);
      #1 rst = 1'b1; rd_n = 1'b1; wr_n = 1'b1; far_wr = 1'b0;
      @(posedge clk);
      #1 rst = 1'b0;
      cyc(21'h101000, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0);
      check("R10 ctl cleared by reset", rdata, 16'h0000);
      cyc(21'h101002, 1'b0, 1'b1, 16'h0, 1'b0, 1'b0);
      check("R10 flag and status cleared by reset", rdata, 16'h0000);
      idle();

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule